// File: doc/BRIEF.md
# Defect Interrupt Tree

This block turns a vector of live defect indications into one interrupt line. Live defects first pass through a correlation stage, in which a parameter map names, for each defect, the higher-order defects that explain it. While any of those is active the lower-order defect reads as inactive, so a single fault raises one event and not a cascade. The correlated vector is registered, and its transitions are captured into sticky latched bits. An edge-select field chooses whether rising edges, falling edges or both set a latch.

Latched bits are split into two groups, general and protection switching. Each group forms a summary: the OR of its latched bits whose per-defect mask is clear. Each summary has its own mask. The unmasked summaries are ORed, gated by a global enable, and registered onto the interrupt pin. Software reaches the block through a simple word port. The port has one write strobe with a write address, and a separate read address that drives combinational read data.

Top module: `defect_irq_tree`

## Requirements
- R1: With the default map, defect 0 suppresses defects 1 and 2, and defect 6 suppresses defect 7. A suppressed defect reads 0 in live status and does not set its latch.
- R2: Address 0 returns the correlated live status one clock edge after the input changes. A write to address 0 has no effect.
- R3: Address 5 bits [1:0] select the capture edge: 0 means both edges, 1 rising only, 2 falling only, 3 both edges. Bit 2 is the interrupt enable.
- R4: Address 1 returns the latched bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: A latch sets on the second clock edge after a qualifying input change. The interrupt rises on the third.
- R6: When a qualifying edge and a write-1 clear hit the same latch bit in the same cycle, the bit stays set.
- R7: Address 2 holds the per-defect masks, where 1 means masked. Defects 0 to 5 form the general group and defects 6 to 9 form the protection group. Address 4 reads the summaries: bit 0 is general and bit 1 is protection.
- R8: Address 3 holds the summary masks: bit 0 masks the general summary and bit 1 masks the protection summary. The interrupt is the OR of the unmasked summaries.
- R9: While the enable bit is 0 the interrupt output stays low, whatever the latched state.
- R10: The interrupt is registered. It falls one clock edge after a write that clears the last contributing latch, masks it, or disables the output.
- R11: Synchronous reset gives latches 0, all defect masks 1, both summary masks 1, address 5 equal to 0, and interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| defIn | input | NUM_GEN+NUM_APS | Live defect indications |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | NUM_GEN+NUM_APS | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | NUM_GEN+NUM_APS | Combinational read data |
| irq | output | 1 | Registered active-high interrupt |

## Verification
The bench looks for a corrupted latch or mask at two places: in the latched or summary readback, and in the interrupt, which moves one edge after the write that should have changed it. An edge detector that is wrong or mis-timed shows up as a latch that sets one edge early, one edge late, or on the wrong polarity. Broken correlation shows up as a lower-order bit in live status, or as a latch set while its parent is active.

// File: rtl/irqtree_pkg.sv
package irqtree_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LIVE    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LATCH   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DEFMASK = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SUMMASK = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SUMMARY = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 3'd5;

  typedef enum logic [1:0] {
    EDGE_BOTH     = 2'd0,
    EDGE_RISE     = 2'd1,
    EDGE_FALL     = 2'd2,
    EDGE_BOTH_ALT = 2'd3
  } edgeMode_e;

  typedef struct packed {
    logic      clrLatch;
    logic      wrDefMask;
    logic      wrSumMask;
    edgeMode_e edgeMode;
    logic      hintEn;
  } ctrlCmd_t;
endpackage

// File: rtl/irqtree_ctrl.sv
module irqtree_ctrl
  import irqtree_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrCtrlData,
  output ctrlCmd_t          cmd
);
  logic [1:0] edgeQ;
  logic       enQ;
  logic       ctrlWrite;

  assign ctrlWrite = wrEn && (wrAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeQ <= 2'd0;
      enQ   <= 1'b0;
    end else if (ctrlWrite) begin
      edgeQ <= wrCtrlData[1:0];
      enQ   <= wrCtrlData[2];
    end
  end

  always_comb begin
    cmd.clrLatch  = wrEn && (wrAddr == ADDR_LATCH);
    cmd.wrDefMask = wrEn && (wrAddr == ADDR_DEFMASK);
    cmd.wrSumMask = wrEn && (wrAddr == ADDR_SUMMASK);
    cmd.edgeMode  = edgeMode_e'(edgeQ);
    cmd.hintEn    = enQ;
  end

  AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_CTRL) |=> (cmd.edgeMode == edgeMode_e'($past(wrCtrlData[1:0])))); // R3

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrAddr == ADDR_CTRL) |=> $stable(cmd.hintEn)); // R9
endmodule

// File: rtl/irqtree_dp.sv
module irqtree_dp
  import irqtree_pkg::*;
#(
  parameter int NUM_GEN = 6,
  parameter int NUM_APS = 4,
  parameter logic [(NUM_GEN+NUM_APS)*(NUM_GEN+NUM_APS)-1:0] SUPP_MAP = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_GEN+NUM_APS-1:0] defIn,
  input  ctrlCmd_t                   cmd,
  input  logic [NUM_GEN+NUM_APS-1:0] wrData,
  output logic [NUM_GEN+NUM_APS-1:0] liveStat,
  output logic [NUM_GEN+NUM_APS-1:0] latched,
  output logic [NUM_GEN+NUM_APS-1:0] defMask,
  output logic [1:0]                 sumMask,
  output logic [1:0]                 summary,
  output logic                       irq
);
  localparam int NUM_DEF = NUM_GEN + NUM_APS;

  logic [NUM_DEF-1:0] corrNow;
  logic [NUM_DEF-1:0] defQ;
  logic [NUM_DEF-1:0] prevQ;
  logic [NUM_DEF-1:0] riseVec;
  logic [NUM_DEF-1:0] fallVec;
  logic [NUM_DEF-1:0] setVec;
  logic [NUM_DEF-1:0] clrVec;
  logic [NUM_DEF-1:0] latQ;
  logic [NUM_DEF-1:0] maskQ;
  logic [1:0]         sumMaskQ;
  logic               irqQ;
  logic [NUM_DEF-1:0] openVec;

  // correlation: a defect is held low while any of its parents is active
  for (genvar g = 0; g < NUM_DEF; g++) begin : gCorr
    logic parentHit;
    assign parentHit  = |(defIn & SUPP_MAP[g*NUM_DEF +: NUM_DEF]);
    assign corrNow[g] = defIn[g] & ~parentHit;

    AST_CORR_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
      defQ[g] |-> !(|(defQ & SUPP_MAP[g*NUM_DEF +: NUM_DEF]))); // R1
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      defQ  <= '0;
      prevQ <= '0;
    end else begin
      defQ  <= corrNow;
      prevQ <= defQ;
    end
  end

  assign riseVec = defQ & ~prevQ;
  assign fallVec = ~defQ & prevQ;

  always_comb begin
    case (cmd.edgeMode)
      EDGE_RISE: setVec = riseVec;
      EDGE_FALL: setVec = fallVec;
      default:   setVec = riseVec | fallVec;
    endcase
  end

  assign clrVec = cmd.clrLatch ? wrData : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) latQ <= '0;
    else     latQ <= (latQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ    <= '1;
      sumMaskQ <= 2'b11;
    end else begin
      if (cmd.wrDefMask) maskQ    <= wrData;
      if (cmd.wrSumMask) sumMaskQ <= wrData[1:0];
    end
  end

  assign openVec    = latQ & ~maskQ;
  assign summary[0] = |openVec[NUM_GEN-1:0];
  assign summary[1] = |openVec[NUM_DEF-1:NUM_GEN];

  always_ff @(posedge clk) begin
    if (rst) irqQ <= 1'b0;
    else     irqQ <= cmd.hintEn & (|(summary & ~sumMaskQ));
  end

  assign liveStat = defQ;
  assign latched  = latQ;
  assign defMask  = maskQ;
  assign sumMask  = sumMaskQ;
  assign irq      = irqQ;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((latQ & $past(clrVec & ~setVec)) == '0)); // R4

  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (($past(latQ & ~clrVec) & ~latQ) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((($past(defQ ^ prevQ) & $past(clrVec)) & ~latQ & $past(setVec)) == '0)); // R6

  AST_NEW_LATCH_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (((latQ & ~$past(latQ)) & ~$past(defQ ^ prevQ)) == '0)); // R3

  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd.edgeMode) == EDGE_RISE) |->
      (((latQ & ~$past(latQ)) & ~$past(defQ & ~prevQ)) == '0)); // R3

  AST_IRQ_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd.hintEn) |-> !irqQ); // R9

  AST_IRQ_NEEDS_OPEN_LATCH: assert property (@(posedge clk) disable iff (rst)
    irqQ |-> $past(|(latQ & ~maskQ))); // R7
endmodule

// File: rtl/defect_irq_tree.sv
module defect_irq_tree
  import irqtree_pkg::*;
#(
  parameter int NUM_GEN = 6,
  parameter int NUM_APS = 4,
  parameter logic [(NUM_GEN+NUM_APS)*(NUM_GEN+NUM_APS)-1:0] SUPP_MAP =
    100'h0000010000000000000100400
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_GEN+NUM_APS-1:0] defIn,
  input  logic                       wrEn,
  input  logic [2:0]                 wrAddr,
  input  logic [NUM_GEN+NUM_APS-1:0] wrData,
  input  logic [2:0]                 rdAddr,
  output logic [NUM_GEN+NUM_APS-1:0] rdData,
  output logic                       irq
);
  localparam int NUM_DEF = NUM_GEN + NUM_APS;

  ctrlCmd_t           cmd;
  logic [NUM_DEF-1:0] liveStat;
  logic [NUM_DEF-1:0] latched;
  logic [NUM_DEF-1:0] defMask;
  logic [1:0]         sumMask;
  logic [1:0]         summary;

  irqtree_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrCtrlData (wrData[2:0]),
    .cmd        (cmd)
  );

  irqtree_dp #(
    .NUM_GEN  (NUM_GEN),
    .NUM_APS  (NUM_APS),
    .SUPP_MAP (SUPP_MAP)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .defIn    (defIn),
    .cmd      (cmd),
    .wrData   (wrData),
    .liveStat (liveStat),
    .latched  (latched),
    .defMask  (defMask),
    .sumMask  (sumMask),
    .summary  (summary),
    .irq      (irq)
  );

  always_comb begin
    case (rdAddr)
      ADDR_LIVE:    rdData = liveStat;
      ADDR_LATCH:   rdData = latched;
      ADDR_DEFMASK: rdData = defMask;
      ADDR_SUMMASK: rdData = NUM_DEF'(sumMask);
      ADDR_SUMMARY: rdData = NUM_DEF'(summary);
      ADDR_CTRL:    rdData = NUM_DEF'({cmd.hintEn, cmd.edgeMode});
      default:      rdData = '0;
    endcase
  end
endmodule

// File: tb/sim_defect_irq_tree.sv
module sim_defect_irq_tree;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 8;
  // {defect input, expected live status}
  localparam logic [19:0] VEC [NV] = '{
    {10'h000, 10'h000}, {10'h001, 10'h001}, {10'h007, 10'h001},
    {10'h006, 10'h006}, {10'h0C0, 10'h040}, {10'h080, 10'h080},
    {10'h3FF, 10'h379}, {10'h038, 10'h038}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] defIn = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [9:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [9:0] rdData;
  logic       irq;
  int         checks = 0;
  int         failures = 0;
  logic [9:0] got;

  defect_irq_tree u0 (
    .clk(clk), .rst(rst), .defIn(defIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [9:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [9:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R11 reset state
    readReg(3'd1, got); check("R11 latches", got, 10'h000);
    readReg(3'd2, got); check("R11 defect masks", got, 10'h3FF);
    readReg(3'd3, got); check("R11 summary masks", got, 10'h003);
    readReg(3'd5, got); check("R11 control", got, 10'h000);
    check("R11 irq", {9'd0, irq}, 10'h000);

    // R1 / R2 correlation table
    for (int i = 0; i < NV; i++) begin
      defIn = VEC[i][19:10];
      step(1);
      readReg(3'd0, got);
      check("R1 R2 live status", got, VEC[i][9:0]);
    end
    writeReg(3'd0, 10'h000);
    readReg(3'd0, got); check("R2 live read-only", got, 10'h038);

    defIn = '0; step(3);
    writeReg(3'd1, 10'h3FF);
    readReg(3'd1, got); check("R4 clear all", got, 10'h000);

    // R5 latency, both edges
    defIn = 10'h008; step(1);
    readReg(3'd1, got); check("R5 not yet latched", got, 10'h000);
    step(1);
    readReg(3'd1, got); check("R5 latched", got, 10'h008);
    writeReg(3'd1, 10'h000);
    readReg(3'd1, got); check("R4 zero write keeps", got, 10'h008);
    writeReg(3'd1, 10'h008);
    readReg(3'd1, got); check("R4 one write clears", got, 10'h000);
    defIn = 10'h000; step(2);
    readReg(3'd1, got); check("R3 both mode falling", got, 10'h008);
    writeReg(3'd1, 10'h008);

    // R3 rising only
    writeReg(3'd5, 10'h001);
    defIn = 10'h010; step(2);
    readReg(3'd1, got); check("R3 rise mode rising", got, 10'h010);
    writeReg(3'd1, 10'h010);
    defIn = 10'h000; step(3);
    readReg(3'd1, got); check("R3 rise mode ignores fall", got, 10'h000);

    // R3 falling only
    writeReg(3'd5, 10'h002);
    defIn = 10'h020; step(3);
    readReg(3'd1, got); check("R3 fall mode ignores rise", got, 10'h000);
    defIn = 10'h000; step(2);
    readReg(3'd1, got); check("R3 fall mode falling", got, 10'h020);
    writeReg(3'd1, 10'h020);

    // R6 set beats clear
    writeReg(3'd5, 10'h000);
    defIn = 10'h100; step(1);
    writeReg(3'd1, 10'h100);
    readReg(3'd1, got); check("R6 set wins", got, 10'h100);

    // R7 R8 R9 R10 tree
    writeReg(3'd2, 10'h2FF);
    writeReg(3'd3, 10'h001);
    readReg(3'd4, got); check("R7 summary", got, 10'h002);
    step(1);
    check("R9 disabled irq", {9'd0, irq}, 10'h000);
    writeReg(3'd5, 10'h004);
    check("R10 irq registered", {9'd0, irq}, 10'h000);
    step(1);
    check("R10 irq rises", {9'd0, irq}, 10'h001);
    writeReg(3'd3, 10'h003);
    check("R8 before mask takes", {9'd0, irq}, 10'h001);
    step(1);
    check("R8 summary masked", {9'd0, irq}, 10'h000);
    writeReg(3'd3, 10'h001); step(1);
    check("R8 summary unmasked", {9'd0, irq}, 10'h001);
    writeReg(3'd2, 10'h3FF); step(1);
    check("R7 defect masked irq", {9'd0, irq}, 10'h000);
    readReg(3'd4, got); check("R7 summary masked", got, 10'h000);
    writeReg(3'd2, 10'h2FF); step(1);
    check("R7 defect unmasked", {9'd0, irq}, 10'h001);
    writeReg(3'd1, 10'h100);
    step(1);
    check("R10 clear drops irq", {9'd0, irq}, 10'h000);
    readReg(3'd1, got); check("R4 cleared bit", got, 10'h000);

    // R5 end-to-end latency on the general group
    writeReg(3'd2, 10'h2FE);
    writeReg(3'd3, 10'h000);
    defIn = 10'h101; step(1);
    check("R5 irq edge 1", {9'd0, irq}, 10'h000);
    step(1);
    check("R5 irq edge 2", {9'd0, irq}, 10'h000);
    readReg(3'd1, got); check("R5 latch edge 2", got, 10'h001);
    step(1);
    check("R5 irq edge 3", {9'd0, irq}, 10'h001);

    // R1 suppressed child not latched
    defIn = 10'h103; step(3);
    readReg(3'd0, got); check("R1 child hidden", got, 10'h101);
    readReg(3'd1, got); check("R1 child not latched", got, 10'h001);

    // R9 disable
    writeReg(3'd5, 10'h000);
    step(1);
    check("R9 disable drops irq", {9'd0, irq}, 10'h000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule